// File: doc/BRIEF.md
# Dual-Bank Data Register File with Interrupt Context Swap

This block is a general-purpose data register file of 16 words with a full duplicate bank. One bank holds the main program context and the other holds the interrupt context. On an interrupt-entry strobe the file switches to the other bank in a single clock cycle. On an interrupt-return strobe it switches back just as fast. No data is copied: a bank-select bit is toggled, and the untouched bank keeps the saved context.

Two combinational read ports and two write ports allow two operand fetches and two result write-backs in every cycle. Both write ports can target any register. The block reports which bank is active. It also keeps a sticky flag that records an entry attempt made while the interrupt context is already in use, because nesting is not supported.

Top module: `shadow_regfile`

## Requirements
- R1: After reset every register in both banks reads 0, `shadow_active` is 0 (main bank), and `nest_overflow` is 0.
- R2: Read ports A and B return, in the same cycle and without a clock edge, the register of the currently active bank selected by their 4-bit addresses.
- R3: Each write port stores its data into the addressed register of the active bank at the rising edge, so a read in the next cycle returns it. Both ports may write in one cycle. When both ports write the same address, port B's data is stored.
- R4: `irq_enter` while the main bank is active makes the shadow bank active from the next cycle (`shadow_active`=1). Neither bank's contents change because of the switch.
- R5: `irq_return` while the shadow bank is active makes the main bank active from the next cycle (`shadow_active`=0). Neither bank's contents change because of the switch.
- R6: `irq_enter` while the shadow bank is active does not switch banks. It sets `nest_overflow`, which stays 1 until reset. If `irq_return` is asserted in the same cycle, the return still takes effect.
- R7: `irq_return` while the main bank is active is ignored: the bank does not change and no flag is raised.
- R8: A write issued in the same cycle as a bank switch lands in the bank that was active before the switch.
- R9: In the cycle right after a switch, both read ports return the contents of the newly selected bank.
- R10: Writes made while the shadow bank is active leave every main-bank register unchanged once the return has taken place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 4 | Read port A register index |
| rd_data_a | output | 32 | Read port A data from the active bank |
| rd_addr_b | input | 4 | Read port B register index |
| rd_data_b | output | 32 | Read port B data from the active bank |
| wr_en_a | input | 1 | Write port A enable |
| wr_addr_a | input | 4 | Write port A register index |
| wr_data_a | input | 32 | Write port A data |
| wr_en_b | input | 1 | Write port B enable (wins on equal address) |
| wr_addr_b | input | 4 | Write port B register index |
| wr_data_b | input | 32 | Write port B data |
| irq_enter | input | 1 | Interrupt entry strobe, switches to the shadow bank |
| irq_return | input | 1 | Interrupt return strobe, switches back to the main bank |
| shadow_active | output | 1 | 1 while the shadow bank is selected |
| nest_overflow | output | 1 | Sticky flag for an entry attempted while the shadow bank was active |

## Verification
Two events can fall in the same cycle: a register write and a bank switch, and also two writes to one address. The directed part forces each case. It writes on both ports in the very cycle that `irq_enter` or `irq_return` is pulsed. It then reads the targeted register from both banks after the switch, to judge that the data landed only in the pre-switch bank. Equal-address double writes are checked by reading back port B's value. Random traffic mixes all these cases. Every read is compared against a two-bank bench model, and after each return the main context is compared word by word.

// File: rtl/shadow_rf_pkg.sv
package shadow_rf_pkg;
  typedef enum logic {
    BANK_MAIN   = 1'b0,
    BANK_SHADOW = 1'b1
  } bank_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/srf_bank_ctrl.sv
module srf_bank_ctrl
  import shadow_rf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  irq_enter,
  input  logic  irq_return,
  output bank_e bank_sel,
  output logic  overflow
);
  bank_e sel_q, sel_d;
  logic  ovf_q, ovf_d;

  always_comb begin
    sel_d = sel_q;
    if (irq_enter && sel_q == BANK_MAIN)
      sel_d = BANK_SHADOW;
    else if (irq_return && sel_q == BANK_SHADOW)
      sel_d = BANK_MAIN;
    ovf_d = ovf_q | (irq_enter && sel_q == BANK_SHADOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= BANK_MAIN;
      ovf_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      ovf_q <= ovf_d;
    end
  end

  assign bank_sel = sel_q;
  assign overflow = ovf_q;

  // R4: entry from main context selects the shadow bank
  a_r4_enter_swaps: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && bank_sel == BANK_MAIN) |=> bank_sel == BANK_SHADOW);
  // R5: return from shadow context restores the main bank
  a_r5_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && bank_sel == BANK_SHADOW) |=> bank_sel == BANK_MAIN);
  // R6: nested entry raises the flag
  a_r6_nest_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && bank_sel == BANK_SHADOW) |=> overflow);
  // R6: flag is sticky
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R7: without a strobe the selection holds
  a_r7_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_enter && !irq_return) |=> $stable(bank_sel));
  // R7: stray return in main context changes nothing
  a_r7_stray_return: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_enter && bank_sel == BANK_MAIN) |=> (bank_sel == BANK_MAIN && overflow == $past(overflow)));
endmodule

// File: rtl/srf_bank.sv
module srf_bank #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_active,
  input  logic              we_a,
  input  logic [AW-1:0]     wa_a,
  input  logic [DATA_W-1:0] wd_a,
  input  logic              we_b,
  input  logic [AW-1:0]     wa_b,
  input  logic [DATA_W-1:0] wd_b,
  input  logic [AW-1:0]     ra_a,
  input  logic [AW-1:0]     ra_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  logic [DATA_W-1:0] mem_q [NREG];
  logic [DATA_W-1:0] mem_d [NREG];
  logic              en_a, en_b;

  assign en_a = bank_active && we_a;
  assign en_b = bank_active && we_b;

  always_comb begin
    for (int i = 0; i < NREG; i++) mem_d[i] = mem_q[i];
    if (en_a) mem_d[wa_a] = wd_a;
    if (en_b) mem_d[wa_b] = wd_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_a = mem_q[ra_a];
  assign rd_b = mem_q[ra_b];

  // R3: port B data is stored, also on an address collision
  a_r3_port_b_store: assert property (@(posedge clk) disable iff (!rst_n)
    en_b |=> mem_q[$past(wa_b)] == $past(wd_b));
  // R3: port A data is stored when B does not collide
  a_r3_port_a_store: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a && !(en_b && wa_b == wa_a)) |=> mem_q[$past(wa_a)] == $past(wd_a));
  // R8/R10: an inactive bank keeps the word it is read at
  a_r10_idle_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_active |=> mem_q[$past(ra_a)] == $past(rd_a));
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import shadow_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en_a,
  input  logic [AW-1:0]     wr_addr_a,
  input  logic [DATA_W-1:0] wr_data_a,
  input  logic              wr_en_b,
  input  logic [AW-1:0]     wr_addr_b,
  input  logic [DATA_W-1:0] wr_data_b,
  input  logic              irq_enter,
  input  logic              irq_return,
  output logic              shadow_active,
  output logic              nest_overflow
);
  bank_e             bank_sel;
  logic [DATA_W-1:0] bank_rd_a [NUM_BANKS];
  logic [DATA_W-1:0] bank_rd_b [NUM_BANKS];

  srf_bank_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_enter (irq_enter),
    .irq_return(irq_return),
    .bank_sel  (bank_sel),
    .overflow  (nest_overflow)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    srf_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_active(bank_sel == bank_e'(b)),
      .we_a       (wr_en_a),
      .wa_a       (wr_addr_a),
      .wd_a       (wr_data_a),
      .we_b       (wr_en_b),
      .wa_b       (wr_addr_b),
      .wd_b       (wr_data_b),
      .ra_a       (rd_addr_a),
      .ra_b       (rd_addr_b),
      .rd_a       (bank_rd_a[b]),
      .rd_b       (bank_rd_b[b])
    );
  end

  assign shadow_active = (bank_sel == BANK_SHADOW);
  assign rd_data_a     = shadow_active ? bank_rd_a[1] : bank_rd_a[0];
  assign rd_data_b     = shadow_active ? bank_rd_b[1] : bank_rd_b[0];

  // R9: after an entry, reads come from the shadow bank
  a_r9_read_new_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && !shadow_active) |=> rd_data_a == bank_rd_a[1]);
endmodule

// File: tb/shadow_regfile_tb_top.sv
`timescale 1ns/1ps
module shadow_regfile_tb_top;
  localparam int DW = 32;
  localparam int NR = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    ra_a = '0, ra_b = '0, wa_a = '0, wa_b = '0;
  logic [DW-1:0] wd_a = '0, wd_b = '0;
  logic          we_a = 1'b0, we_b = 1'b0, ent = 1'b0, ret = 1'b0;
  logic [DW-1:0] rda, rdb;
  logic          sh_act, ovf;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [DW-1:0] m_bank [2][NR];
  logic          m_sel;
  logic          m_ovf;

  always #10 clk = ~clk;

  shadow_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(ra_a), .rd_data_a(rda),
    .rd_addr_b(ra_b), .rd_data_b(rdb),
    .wr_en_a(we_a), .wr_addr_a(wa_a), .wr_data_a(wd_a),
    .wr_en_b(we_b), .wr_addr_b(wa_b), .wr_data_b(wd_b),
    .irq_enter(ent), .irq_return(ret),
    .shadow_active(sh_act), .nest_overflow(ovf)
  );

  function automatic logic [DW-1:0] exp_read(input logic [3:0] a);
    return m_bank[m_sel][a];
  endfunction

  task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive after negedge, compare outputs, then advance model at posedge
  task automatic step(input string tag, input logic e_a, input logic [3:0] a_a, input logic [DW-1:0] d_a,
                      input logic e_b, input logic [3:0] a_b, input logic [DW-1:0] d_b,
                      input logic en, input logic rt, input logic [3:0] r_a, input logic [3:0] r_b);
    @(negedge clk);
    we_a = e_a; wa_a = a_a; wd_a = d_a;
    we_b = e_b; wa_b = a_b; wd_b = d_b;
    ent = en; ret = rt; ra_a = r_a; ra_b = r_b;
    #2;
    check(tag, "rd_data_a", rda, exp_read(r_a));
    check(tag, "rd_data_b", rdb, exp_read(r_b));
    check(tag, "shadow_active", {31'd0, sh_act}, {31'd0, m_sel});
    check(tag, "nest_overflow", {31'd0, ovf}, {31'd0, m_ovf});
    @(posedge clk);
    if (e_a) m_bank[m_sel][a_a] = d_a;
    if (e_b) m_bank[m_sel][a_b] = d_b;
    if (en && m_sel) m_ovf = 1'b1;
    if (en && !m_sel) m_sel = 1'b1;
    else if (rt && m_sel) m_sel = 1'b0;
  endtask

  task automatic idle_read(input string tag, input logic [3:0] r_a, input logic [3:0] r_b);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, r_a, r_b);
  endtask

  task automatic sweep_main(input string tag);
    for (int i = 0; i < NR; i += 2) idle_read(tag, 4'(i), 4'(i + 1));
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NR; i++) m_bank[b][i] = '0;
    m_sel = 1'b0;
    m_ovf = 1'b0;
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state of every register and flag
    sweep_main("R1");

    // R2/R3: fill main context on both ports
    for (int i = 0; i < NR; i += 2)
      step("R3", 1, 4'(i), 32'hA000_0000 + i, 1, 4'(i + 1), 32'hA000_0000 + i + 1, 0, 0, 4'(i), 4'(i + 1));
    sweep_main("R2");
    // R3: collision, port B wins
    step("R3", 1, 4'd5, 32'h1111_1111, 1, 4'd5, 32'h2222_2222, 0, 0, 4'd5, 4'd5);
    idle_read("R3", 4'd5, 4'd4);

    // R7: stray return in main context
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 4'd0, 4'd1);
    idle_read("R7", 4'd2, 4'd3);

    // R8: write in the entry cycle goes to main bank; R4 switch
    step("R8", 1, 4'd7, 32'hC0DE_0007, 1, 4'd8, 32'hC0DE_0008, 1, 0, 4'd7, 4'd8);
    // R9: next cycle reads shadow (zeros)
    idle_read("R9", 4'd7, 4'd8);
    // R10: interrupt context writes
    for (int i = 0; i < NR; i += 2)
      step("R10", 1, 4'(i), 32'h5000_0000 + i, 1, 4'(i + 1), 32'h5000_0000 + i + 1, 0, 0, 4'(i), 4'(i + 1));
    // R6: nested entry ignored and flagged
    step("R6", 0, 0, 0, 0, 0, 0, 1, 0, 4'd0, 4'd1);
    idle_read("R6", 4'd2, 4'd3);
    // R8: write in the return cycle goes to shadow bank; R5 restore
    step("R8", 1, 4'd7, 32'h5EAD_0007, 0, 0, 0, 0, 1, 4'd7, 4'd8);
    idle_read("R5", 4'd7, 4'd8);
    // R10: main context intact after return
    sweep_main("R10");
    // R4: re-enter, shadow contents preserved across switches
    step("R4", 0, 0, 0, 0, 0, 0, 1, 0, 4'd7, 4'd0);
    idle_read("R4", 4'd7, 4'd0);
    // R6: entry and return together in shadow context: return wins
    step("R6", 0, 0, 0, 0, 0, 0, 1, 1, 4'd1, 4'd2);
    idle_read("R6", 4'd1, 4'd2);

    // random phase covering all requirements
    for (int n = 0; n < 4000; n++) begin
      step("R2", 1'($urandom % 2), 4'($urandom), $urandom,
                 1'($urandom % 2), 4'($urandom), $urandom,
                 ($urandom % 8) == 0, ($urandom % 8) == 0,
                 4'($urandom), 4'($urandom));
      if (!m_sel && (n % 500) == 499) sweep_main("R10");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule